// File: doc/BRIEF.md
# Block-transfer configuration register target on a two-wire serial bus

This block is a serial-bus target that keeps seven 8-bit configuration registers for a clock-generator controller. It runs entirely on the system clock. SCL and SDA are oversampled through a synchronizer. START and STOP conditions and the bit edges are recovered from the synchronized samples. A byte shifter and a protocol state machine then handle the transfer.

A host writes by sending the write address, then a command byte, then a byte-count byte, then data. The command and byte-count bytes are acknowledged and thrown away. The data bytes fill the registers starting at register 0 and moving upward until a STOP. A host reads by sending the read address. The target answers with a byte count of 6, followed by registers 0 to 5. No register index is ever carried on the bus.

The register contents are driven as one parallel vector to the rest of the controller. Register k occupies bits 8k+7 down to 8k. The target pulls SDA low through an open-drain enable, and the pad itself sits outside the block.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: While reset is asserted, regs_o is 56'h06_00_00_03_FF_FF_FF, with register 0 in the low byte. This means registers 0 to 2 (the clock-group enables) are all ones, register 3 is 0x03, registers 4 and 5 are 0x00, and register 6 is 0x06.
- R2: After a START, the 8-bit address byte 0xD2 (write) and the address byte 0xD3 (read) are each acknowledged. Acknowledging means SDA is held low during the ninth SCL high phase.
- R3: Any other address byte gets no acknowledge. Every following byte in that transfer also gets no acknowledge and changes no register, until the next START.
- R4: In a write, the first two bytes after the address (command and byte count) are acknowledged and discarded. Each later data byte is acknowledged and stored in the next register, starting at register 0.
- R5: A write may stop after any complete byte. The registers written so far keep their new values and the others are unchanged. A byte cut short by a STOP has no effect.
- R6: Registers 5 and 6 are write-protected. Data bytes aimed at them, and data bytes beyond register 6, are acknowledged but leave regs_o unchanged.
- R7: In a read, the target sends the byte count 6 and then registers 0 to 5, each most significant bit first.
- R8: When the host does not acknowledge a byte during a read, the target releases SDA, so SDA reads as 1 on every following bit, until the next START or STOP.
- R9: A repeated START, with no STOP before it, restarts the address phase from any state.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | 56 | Register contents, register k in bits 8k+7:8k |

## Verification
Writes are swept over every length, from the address alone up to a run that goes past the last register. Each length uses its own arithmetic data pattern, and the command and count bytes carry values of their own. This shows whether the header bytes are discarded, whether the data lands at the right index, whether an early STOP is honoured, and whether the protected registers and out-of-range bytes are ignored. Every write is followed by a full block read, which separates a fault in the count byte or the read order from a fault in storage. A sweep of foreign addresses, a NACK-terminated read, a byte cut short by a STOP, and repeated STARTs in both directions exercise the exit paths of the state machine.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_WAIT
  } link_st_e;
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int              NREG      = 7,
  parameter int              RD_LEN    = 6,
  parameter int              IDXW      = 5,
  parameter logic [NREG*8-1:0] DEFAULTS = '0,
  parameter logic [NREG-1:0] PROT_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [NREG*8-1:0] regs_o
);
  // bus index 0 and 1 are the discarded header bytes
  localparam int HDR = 2;

  logic [7:0] regs [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    if (PROT_MASK[k]) begin : g_ro
      assign regs[k] = DEFAULTS[8*k +: 8];
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          regs[k] <= DEFAULTS[8*k +: 8];
        else if (we_i && idx_i == IDXW'(k + HDR))
          regs[k] <= wdata_i;
      end
    end
    assign regs_o[8*k +: 8] = regs[k];
  end

  // read stream: index 0 is the count, then registers from 0
  always_comb begin
    rdata_o = 8'hFF;
    if (idx_i == '0) rdata_o = 8'(RD_LEN);
    for (int k = 0; k < RD_LEN; k++) begin
      if (idx_i == IDXW'(k + 1)) rdata_o = regs[k];
    end
  end
endmodule

// File: rtl/cfg_link_fsm.sv
module cfg_link_fsm
  import clkcfg_pkg::*;
#(
  parameter int         IDXW    = 5,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sda_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [7:0]      rd_byte_i,
  output logic            sda_oe_o,
  output logic            we_o,
  output logic [IDXW-1:0] idx_o,
  output logic [7:0]      wdata_o,
  output link_st_e        state_o
);
  link_st_e        state;
  logic [7:0]      shreg;
  logic [2:0]      bit_cnt;
  logic            rx_full, addr_phase, rd_mode, rack_ok, sda_oe;
  logic [IDXW-1:0] byte_idx;
  logic [IDXW-1:0] idx_next;

  assign idx_next = (byte_idx == '1) ? byte_idx : byte_idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      rx_full    <= 1'b0;
      addr_phase <= 1'b0;
      rd_mode    <= 1'b0;
      rack_ok    <= 1'b0;
      sda_oe     <= 1'b0;
      byte_idx   <= '0;
    end else if (start_i) begin
      state      <= ST_RX;
      addr_phase <= 1'b1;
      rd_mode    <= 1'b0;
      bit_cnt    <= '0;
      rx_full    <= 1'b0;
      byte_idx   <= '0;
      sda_oe     <= 1'b0;
    end else if (stop_i) begin
      state   <= ST_IDLE;
      rx_full <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise_i) begin
            shreg   <= {shreg[6:0], sda_i};
            bit_cnt <= bit_cnt + 3'd1;
            rx_full <= (bit_cnt == 3'd7);
          end else if (scl_fall_i && rx_full) begin
            rx_full <= 1'b0;
            if (addr_phase) begin
              addr_phase <= 1'b0;
              if (shreg == WR_ADDR) begin
                rd_mode <= 1'b0;
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
              end else if (shreg == RD_ADDR) begin
                rd_mode <= 1'b1;
                sda_oe  <= 1'b1;
                state   <= ST_ACK;
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              sda_oe   <= 1'b1;
              state    <= ST_ACK;
              byte_idx <= idx_next;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              shreg    <= rd_byte_i;
              sda_oe   <= ~rd_byte_i[7];
              byte_idx <= idx_next;
              state    <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_cnt == 3'd7) begin
              bit_cnt <= '0;
              sda_oe  <= 1'b0;
              state   <= ST_RACK;
            end else begin
              bit_cnt <= bit_cnt + 3'd1;
              shreg   <= {shreg[6:0], 1'b0};
              sda_oe  <= ~shreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            rack_ok <= ~sda_i;
          end else if (scl_fall_i) begin
            if (rack_ok) begin
              shreg    <= rd_byte_i;
              sda_oe   <= ~rd_byte_i[7];
              byte_idx <= idx_next;
              state    <= ST_TX;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign we_o     = (state == ST_RX) && scl_fall_i && rx_full && !addr_phase &&
                    !rd_mode && !start_i && !stop_i;
  assign idx_o    = byte_idx;
  assign wdata_o  = shreg;
  assign sda_oe_o = sda_oe;
  assign state_o  = state;
endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
  import clkcfg_pkg::*;
#(
  parameter int                NREG        = 7,
  parameter int                RD_LEN      = 6,
  parameter int                SYNC_STAGES = 2,
  parameter logic [7:0]        WR_ADDR     = 8'hD2,
  parameter logic [7:0]        RD_ADDR     = 8'hD3,
  parameter logic [NREG*8-1:0] DEFAULTS    = 56'h06_00_00_03_FF_FF_FF,
  parameter logic [NREG-1:0]   PROT_MASK   = 7'b110_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  // room for header bytes plus a saturating tail
  localparam int IDXW = $clog2(NREG + 3) + 1;

  logic            sda_s, scl_rise, scl_fall, start, stop;
  logic            we;
  logic [IDXW-1:0] idx;
  logic [7:0]      wdata, rdata;
  link_st_e        state;

  cfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  cfg_link_fsm #(.IDXW(IDXW), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .rd_byte_i  (rdata),
    .sda_oe_o   (sda_oe_o),
    .we_o       (we),
    .idx_o      (idx),
    .wdata_o    (wdata),
    .state_o    (state)
  );

  cfg_reg_bank #(
    .NREG(NREG), .RD_LEN(RD_LEN), .IDXW(IDXW),
    .DEFAULTS(DEFAULTS), .PROT_MASK(PROT_MASK)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .idx_i   (idx),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .regs_o  (regs_o)
  );
endmodule

// File: rtl/clkcfg_i2c_target_chk.sv
module clkcfg_i2c_target_chk
  import clkcfg_pkg::*;
#(
  parameter int                NREG     = 7,
  parameter logic [NREG*8-1:0] DEFAULTS = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_fall_i,
  input logic              sda_oe_i,
  input link_st_e          state_i,
  input logic [NREG*8-1:0] regs_i
);
  logic [NREG*8-1:0] regs_q;
  logic [NREG-1:0]   chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= DEFAULTS;
    else         regs_q <= regs_i;
  end

  for (genvar k = 0; k < NREG; k++) begin : g_chg
    assign chg[k] = regs_i[8*k +: 8] != regs_q[8*k +: 8];
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_default_R1: assert (regs_i == DEFAULTS)
        else $error("register defaults wrong during reset");
    end
  end

  assert_nack_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT) |-> !sda_oe_i)  // also covers R8
    else $error("SDA driven while waiting for START");

  assert_one_reg_per_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1)
    else $error("more than one register changed in a cycle");

  assert_sda_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> $past(scl_fall_i))
    else $error("SDA drive changed away from an SCL fall");
endmodule

bind clkcfg_i2c_target clkcfg_i2c_target_chk #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_fall_i (scl_fall),
  .sda_oe_i   (sda_oe_o),
  .state_i    (state),
  .regs_i     (regs_o)
);

// File: tb/clkcfg_i2c_target_bench.sv
module clkcfg_i2c_target_bench;
  localparam int Q = 8;
  localparam logic [55:0] DEF = 56'h06_00_00_03_FF_FF_FF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [55:0] regs_o;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  logic [7:0] mdl [7];

  always #5 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  clkcfg_i2c_target u_clkcfg_i2c_target (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs_o)
  );

  // R10 monitor: drive must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && scl && sda_oe !== oe_prev) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] mdl_vec();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[8*k +: 8] = mdl[k];
    return v;
  endfunction

  function automatic logic [7:0] pat(input int seed, input int b);
    return 8'((seed * 29 + b * 71 + 13) & 255);
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    sda_h = 1'b0; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    sda_h = 1'b1; wait_q(); wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; wait_q();
    scl = 1'b1; wait_q(); wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wait_q();
    scl = 1'b1; wait_q();
    b = sda_line; wait_q();
    scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~ack_it);
  endtask

  task automatic read_all();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD3, a);
    chk("R2 read address ack", 64'(a), 64'd1);
    recv_byte(1'b1, d);
    chk("R7 byte count", 64'(d), 64'd6);
    for (int k = 0; k < 6; k++) begin
      recv_byte(k < 5, d);
      chk("R7 read register", 64'(d), 64'(mdl[k]));
    end
    bus_stop();
  endtask

  // t bytes after the address: command, count, then data
  task automatic do_write(input int t, input int seed);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD2, a);
    chk("R2 write address ack", 64'(a), 64'd1);
    for (int b = 0; b < t; b++) begin
      d = pat(seed, b);
      send_byte(d, a);
      if (b < 2)
        chk("R4 header byte ack", 64'(a), 64'd1);
      else if (b - 2 >= 5)
        chk("R6 protected or extra byte ack", 64'(a), 64'd1);
      else
        chk("R4 data byte ack", 64'(a), 64'd1);
      if (b >= 2 && b - 2 < 5) mdl[b-2] = d;
    end
    bus_stop();
    chk("R5 R6 registers after write", 64'(regs_o), 64'(mdl_vec()));
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] adr;
    for (int k = 0; k < 7; k++) mdl[k] = DEF[8*k +: 8];
    repeat (5) @(negedge clk);
    chk("R1 reset defaults", 64'(regs_o), 64'(DEF));
    chk("R1 SDA released in reset", 64'(sda_line), 64'd1);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 defaults after reset", 64'(regs_o), 64'(DEF));

    read_all();

    for (int t = 0; t <= 10; t++) begin
      do_write(t, t + 3);
      read_all();
    end

    // R5: byte cut short by STOP
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R5 partial byte ignored", 64'(regs_o), 64'(mdl_vec()));

    // R3: foreign addresses
    for (int i = 0; i < 20; i++) begin
      adr = 8'((i * 13 + 7) & 255);
      if (i >= 16) adr = 8'hD0 + 8'(i - 16) * 8'd5 / 8'd4;
      if (adr == 8'hD2 || adr == 8'hD3) adr = 8'hD6;
      bus_start();
      send_byte(adr, a);
      chk("R3 foreign address no ack", 64'(a), 64'd0);
      send_byte(8'h00, a);
      chk("R3 later byte no ack", 64'(a), 64'd0);
      send_byte(8'h5A, a);
      chk("R3 later byte no ack", 64'(a), 64'd0);
      bus_stop();
      chk("R3 registers untouched", 64'(regs_o), 64'(mdl_vec()));
    end

    // R8: host NACK ends read
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, d);
    recv_byte(1'b0, d);
    chk("R8 byte before NACK", 64'(d), 64'(mdl[0]));
    recv_byte(1'b0, d);
    chk("R8 SDA released after NACK", 64'(d), 64'hFF);
    bus_stop();
    read_all();

    // R9: repeated START from write into read
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'h00, a);
    send_byte(8'h00, a);
    send_byte(8'hC6, a);
    mdl[0] = 8'hC6;
    bus_start();
    send_byte(8'hD3, a);
    chk("R9 repeated start read ack", 64'(a), 64'd1);
    recv_byte(1'b1, d);
    chk("R9 count after repeated start", 64'(d), 64'd6);
    recv_byte(1'b0, d);
    chk("R9 register 0 after repeated start", 64'(d), 64'hC6);
    // repeated START out of the no-ack wait state
    bus_start();
    send_byte(8'h40, a);
    chk("R3 foreign address no ack", 64'(a), 64'd0);
    bus_start();
    send_byte(8'hD2, a);
    chk("R9 write address ack after foreign", 64'(a), 64'd1);
    send_byte(8'h01, a);
    send_byte(8'h02, a);
    send_byte(8'h3C, a);
    mdl[0] = 8'h3C;
    bus_stop();
    chk("R9 write after repeated start", 64'(regs_o), 64'(mdl_vec()));

    chk("R10 SDA drive stable while SCL high", 64'(viol), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule